// File: doc/BRIEF.md
# Parallel Converter Bus Sequencer

This block sits on the host side of a quad-channel, 16-bit parallel digital-to-analog converter. It takes one command at a time from a simple command port and turns it into pin waveforms on the converter bus. There are four commands: write data into a channel's input register, read a channel's input register back, pulse the load strobe so that every channel's output register takes its input register, and pulse the output-clear line.

Every pulse width, setup time and hold time on the bus is a nanosecond parameter. Each one is turned into a clock-cycle count from the system clock period, so the same block can be reused at another clock rate by changing one parameter. Reads are sampled only after the converter's data-out delay has elapsed. The sampled word comes back with a one-cycle strobe. A busy flag covers the whole time a command runs.

Top module: `dac_bus_seq`

## Requirements
- R1: After reset, chip select, read/write, load and clear are all high (inactive), the data bus driver is off, and busy and read-valid are low.
- R2: A command is taken only while busy is low. Busy is high in the cycle after acceptance and stays high until the command's waveform is complete. A command presented while busy is ignored and changes no channel's contents.
- R3: For a write (op 2'b00), read/write is low and the bus driver is on before chip select falls and throughout the low phase. Chip select is low for exactly ceil(20 ns / period) cycles.
- R4: After chip select rises on a write, the data stays driven and read/write stays low for ceil(15 ns / period) cycles, which also covers the 10 ns read/write hold.
- R5: For a read (op 2'b01), read/write is high and the bus driver is off for at least ceil(30 ns / period) cycles before chip select falls. Chip select is then low for exactly the larger of ceil(40 ns / period) and ceil(80 ns / period) cycles.
- R6: The read word is sampled at the last edge of the chip-select low phase, no earlier than ceil(80 ns / period) cycles after the fall. It is returned on the read-data output with a valid strobe that lasts exactly one cycle.
- R7: Chip select stays high for at least ceil(80 ns / period) cycles between two accesses.
- R8: A load (op 2'b10) drives the load line low for exactly ceil(40 ns / period) cycles, then holds it high for at least that long. Chip select does not fall within ceil(50 ns / period) cycles of the load rising edge, and never overlaps a load pulse.
- R9: A clear (op 2'b11) drives the clear line low for exactly ceil(40 ns / period) cycles, then keeps it high for at least as long before busy drops. Chip select and load stay high during the clear pulse.
- R10: The address lines carry the accepted channel number and stay stable for as long as busy is high.
- R11: Each nanosecond value becomes a cycle count by ceiling division by the clock period, with a floor of one cycle. For example, at a 30 ns period the write low phase is 1 cycle and the read low phase is 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 write, 01 read, 10 load, 11 clear |
| cmd_ch | input | AW | Channel number |
| cmd_data | input | DW | Write data |
| busy | output | 1 | Command in progress |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DW | Read-back word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw_n | output | 1 | High for read, low for write |
| bus_addr | output | AW | Channel address lines |
| bus_ldac_n | output | 1 | Load strobe, update on rising edge |
| bus_clr_n | output | 1 | Output clear, effective on rising edge |
| bus_oe | output | 1 | Host data-bus driver enable |
| bus_dout | output | DW | Data driven toward the converter |
| bus_din | input | DW | Data returned by the converter |

## Verification
Busy is due one cycle after a command is accepted. Each pin edge follows the state register by one clock, so widths are measured as runs of falling-edge samples, counted from the edge where a pin changes. The read model in the bench holds a poison value until the read low phase has lasted ceil(80 ns / period) cycles, so the read word must arrive on the exact edge the delay allows. The strobe must then last one sample. A second instance at a 30 ns period confirms that the cycle counts rescale and that the one-cycle floor applies.

// File: rtl/dac_bus_seq.sv
module dac_bus_seq #(
  parameter int CLK_NS          = 10,
  parameter int DW              = 16,
  parameter int AW              = 2,
  parameter int T_WR_LOW_NS     = 20,
  parameter int T_WR_DHOLD_NS   = 15,
  parameter int T_RW_HOLD_NS    = 10,
  parameter int T_RD_SETUP_NS   = 30,
  parameter int T_RD_LOW_NS     = 40,
  parameter int T_RD_DELAY_NS   = 80,
  parameter int T_CS_HIGH_NS    = 80,
  parameter int T_LD_LOW_NS     = 40,
  parameter int T_LD_HIGH_NS    = 40,
  parameter int T_LD_TO_CS_NS   = 50,
  parameter int T_CLR_LOW_NS    = 40,
  parameter int T_CLR_HIGH_NS   = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_ch,
  input  logic [DW-1:0] cmd_data,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          bus_cs_n,
  output logic          bus_rw_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ldac_n,
  output logic          bus_clr_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_WCS   = cyc(T_WR_LOW_NS);
  localparam int C_WDH   = cyc(T_WR_DHOLD_NS);
  localparam int C_RWH   = cyc(T_RW_HOLD_NS);
  localparam int C_RSU   = cyc(T_RD_SETUP_NS);
  localparam int C_RCS   = cyc(T_RD_LOW_NS);
  localparam int C_RDLY  = cyc(T_RD_DELAY_NS);
  localparam int C_CSH   = cyc(T_CS_HIGH_NS);
  localparam int C_LDL   = cyc(T_LD_LOW_NS);
  localparam int C_LDH   = cyc(T_LD_HIGH_NS);
  localparam int C_LDCS  = cyc(T_LD_TO_CS_NS);
  localparam int C_CLL   = cyc(T_CLR_LOW_NS);
  localparam int C_CLH   = cyc(T_CLR_HIGH_NS);
  localparam int C_WHOLD = mx(C_WDH, C_RWH);
  localparam int C_RLOW  = mx(C_RCS, C_RDLY);
  localparam int CMAX    = mx(mx(mx(C_WCS, C_WHOLD), mx(C_RSU, C_RLOW)),
                              mx(mx(C_LDL, C_LDH), mx(C_CLL, C_CLH)));
  localparam int CW      = $clog2(CMAX + 1);
  localparam int GMAX    = mx(C_CSH, C_LDCS);
  localparam int GW      = $clog2(GMAX + 1);

  typedef enum logic [3:0] {
    IDLE, WR_SET, WR_LOW, WR_HOLD, RD_SET, RD_LOW, RD_HOLD,
    LD_LOW, LD_HIGH, CL_LOW, CL_HIGH
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] cs_gap, ld_gap;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic          wr_phase, gap_ok, cnt_done;

  assign busy       = (st != IDLE);
  assign wr_phase   = (st == WR_SET) || (st == WR_LOW) || (st == WR_HOLD);
  assign bus_cs_n   = !((st == WR_LOW) || (st == RD_LOW));
  assign bus_rw_n   = !wr_phase;
  assign bus_oe     = wr_phase;
  assign bus_ldac_n = (st != LD_LOW);
  assign bus_clr_n  = (st != CL_LOW);
  assign bus_addr   = addr_q;
  assign bus_dout   = wdat_q;
  assign cnt_done   = (cnt == '0);
  assign gap_ok     = (cs_gap >= GW'(C_CSH)) && (ld_gap >= GW'(C_LDCS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_gap <= GW'(GMAX);
      ld_gap <= GW'(GMAX);
    end else begin
      if (!bus_cs_n)               cs_gap <= '0;
      else if (cs_gap != GW'(GMAX)) cs_gap <= cs_gap + 1'b1;
      if (!bus_ldac_n)             ld_gap <= '0;
      else if (ld_gap != GW'(GMAX)) ld_gap <= ld_gap + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdat_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        IDLE: if (cmd_valid) begin
          addr_q <= cmd_ch;
          case (cmd_op)
            2'b00: begin wdat_q <= cmd_data; st <= WR_SET; end
            2'b01: begin st <= RD_SET; cnt <= CW'(C_RSU - 1); end
            2'b10: begin st <= LD_LOW; cnt <= CW'(C_LDL - 1); end
            default: begin st <= CL_LOW; cnt <= CW'(C_CLL - 1); end
          endcase
        end
        WR_SET: if (gap_ok) begin st <= WR_LOW; cnt <= CW'(C_WCS - 1); end
        WR_LOW:
          if (cnt_done) begin st <= WR_HOLD; cnt <= CW'(C_WHOLD - 1); end
          else cnt <= cnt - 1'b1;
        WR_HOLD:
          if (cnt_done) st <= IDLE;
          else cnt <= cnt - 1'b1;
        RD_SET:
          if (!cnt_done) cnt <= cnt - 1'b1;
          else if (gap_ok) begin st <= RD_LOW; cnt <= CW'(C_RLOW - 1); end
        RD_LOW:
          if (cnt_done) begin
            rd_data  <= bus_din;
            rd_valid <= 1'b1;
            st       <= RD_HOLD;
            cnt      <= CW'(C_RWH - 1);
          end else cnt <= cnt - 1'b1;
        RD_HOLD:
          if (cnt_done) st <= IDLE;
          else cnt <= cnt - 1'b1;
        LD_LOW:
          if (cnt_done) begin st <= LD_HIGH; cnt <= CW'(C_LDH - 1); end
          else cnt <= cnt - 1'b1;
        LD_HIGH:
          if (cnt_done) st <= IDLE;
          else cnt <= cnt - 1'b1;
        CL_LOW:
          if (cnt_done) begin st <= CL_HIGH; cnt <= CW'(C_CLH - 1); end
          else cnt <= cnt - 1'b1;
        CL_HIGH:
          if (cnt_done) st <= IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_bus_seq_chk.sv
module dac_bus_seq_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          busy,
  input logic          rd_valid,
  input logic          bus_cs_n,
  input logic          bus_rw_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ldac_n,
  input logic          bus_clr_n,
  input logic          bus_oe
);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R3
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !bus_rw_n) |-> bus_oe);

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && bus_rw_n) |-> !bus_oe);

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_cs_n) && $past(!bus_rw_n)) |-> (bus_oe && !bus_rw_n));

  // R8
  ld_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ldac_n |-> bus_cs_n);

  // R9
  clr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clr_n |-> (bus_cs_n && bus_ldac_n));

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));

endmodule

bind dac_bus_seq dac_bus_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .rd_valid(rd_valid), .bus_cs_n(bus_cs_n), .bus_rw_n(bus_rw_n),
  .bus_addr(bus_addr), .bus_ldac_n(bus_ldac_n), .bus_clr_n(bus_clr_n),
  .bus_oe(bus_oe)
);

// File: tb/dac_bus_seq_tb_top.sv
module dac_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int E_WCS  = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_WDH  = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_RSU  = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_RLOW = (80 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_CSH  = (80 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_PUL  = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_LDCS = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_WCS  = 1;
  localparam int B_RLOW = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [1:0] cmd_ch = 0;
  logic [15:0] cmd_data = 0;
  logic busy, rd_valid, cs_n, rw_n, ldac_n, clr_n, oe;
  logic [15:0] rd_data, dout, din;
  logic [1:0] addr;
  logic busy_b, rv_b, cs_b, rw_b, ld_b, cl_b, oe_b;
  logic [15:0] rd_b, dout_b;
  logic [1:0] addr_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_data(cmd_data), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_cs_n(cs_n), .bus_rw_n(rw_n), .bus_addr(addr),
    .bus_ldac_n(ldac_n), .bus_clr_n(clr_n), .bus_oe(oe), .bus_dout(dout),
    .bus_din(din));

  dac_bus_seq #(.CLK_NS(30)) dut_b (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_data(cmd_data), .busy(busy_b), .rd_valid(rv_b),
    .rd_data(rd_b), .bus_cs_n(cs_b), .bus_rw_n(rw_b), .bus_addr(addr_b),
    .bus_ldac_n(ld_b), .bus_clr_n(cl_b), .bus_oe(oe_b), .bus_dout(dout_b),
    .bus_din(16'h5A5A));

  int nchk = 0, nerr = 0;
  logic [15:0] mem [4];
  logic [15:0] exp_mem [4];
  logic [1:0] cur_op, cur_ch;
  int lo_cs = 0, hi_cs = 100, ld_lo = 0, ld_hi = 100, cl_lo = 0, cl_hi = 100;
  int rdset = 100, whold = 0, lo_b = 0;
  logic p_cs = 1, p_ld = 1, p_cl = 1, p_busy = 0, p_rv = 0, p_oe = 0, p_cs_b = 1;
  logic mon = 0;

  assign din = (!cs_n && rw_n && lo_cs >= E_RLOW) ? mem[addr] : 16'hDEAD;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (mon) begin
    if (!cs_n && p_cs) begin
      chk(hi_cs >= E_CSH, "R7 cs high gap", hi_cs, E_CSH);
      chk(ld_hi >= E_LDCS, "R8 load to cs", ld_hi, E_LDCS);
      if (rw_n) chk(rdset >= E_RSU && !oe, "R5 read setup", rdset, E_RSU);
      else      chk(oe, "R3 write drive", oe, 1);
    end
    if (!cs_n && !p_cs) chk(rw_n == (cur_op == 2'b01), "R3 rw stable", rw_n, cur_op == 2'b01);
    if (cs_n && !p_cs) begin
      if (cur_op == 2'b00) begin
        chk(lo_cs == E_WCS, "R3 write cs low", lo_cs, E_WCS);
        mem[addr] = dout;
      end else chk(lo_cs == E_RLOW, "R5 read cs low", lo_cs, E_RLOW);
    end
    if (!oe && p_oe) chk(whold >= E_WDH, "R4 write hold", whold, E_WDH);
    if (busy && p_busy) chk(addr == cur_ch, "R10 addr stable", addr, cur_ch);
    if (rd_valid) begin
      chk(!p_rv, "R6 strobe width", 2, 1);
      chk(rd_data == exp_mem[cur_ch], "R6 read data", rd_data, exp_mem[cur_ch]);
    end
    if (ldac_n && !p_ld) chk(ld_lo == E_PUL, "R8 load low", ld_lo, E_PUL);
    if (clr_n && !p_cl) begin
      chk(cl_lo == E_PUL, "R9 clear low", cl_lo, E_PUL);
      chk(cs_n && ldac_n, "R9 no overlap", cs_n, 1);
    end
    if (!busy && p_busy) begin
      if (cur_op == 2'b10) chk(ld_hi >= E_PUL, "R8 load high", ld_hi, E_PUL);
      if (cur_op == 2'b11) chk(cl_hi >= E_PUL, "R9 clear high", cl_hi, E_PUL);
    end
    if (cs_b && !p_cs_b) begin
      if (cur_op == 2'b00) chk(lo_b == B_WCS, "R11 write low at 30ns", lo_b, B_WCS);
      else chk(lo_b == B_RLOW, "R11 read low at 30ns", lo_b, B_RLOW);
    end
    if (rv_b) chk(rd_b == 16'h5A5A, "R11 read data at 30ns", rd_b, 16'h5A5A);
    lo_cs = cs_n ? 0 : lo_cs + 1;
    hi_cs = cs_n ? hi_cs + 1 : 0;
    ld_lo = ldac_n ? 0 : ld_lo + 1;
    ld_hi = ldac_n ? ld_hi + 1 : 0;
    cl_lo = clr_n ? 0 : cl_lo + 1;
    cl_hi = clr_n ? cl_hi + 1 : 0;
    rdset = (rw_n && !oe && cs_n) ? rdset + 1 : 0;
    whold = !cs_n ? 0 : ((oe && !rw_n) ? whold + 1 : whold);
    lo_b  = cs_b ? 0 : lo_b + 1;
    p_cs = cs_n; p_ld = ldac_n; p_cl = clr_n; p_busy = busy; p_rv = rd_valid;
    p_oe = oe; p_cs_b = cs_b;
  end

  task automatic issue(input logic [1:0] op, input logic [1:0] ch,
                       input logic [15:0] d, input bit inject);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_op = op; cmd_ch = ch; cmd_data = d; cmd_valid = 1;
    cur_op = op; cur_ch = ch;
    if (op == 2'b00) exp_mem[ch] = d;
    @(negedge clk);
    chk(busy, "R2 busy after accept", busy, 1);
    if (inject) begin
      cmd_op = 2'b00; cmd_ch = 2'd3; cmd_data = 16'hBAD0;
      repeat (2) @(negedge clk);
    end
    cmd_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mem[i] = 0; exp_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && rw_n && ldac_n && clr_n && !oe, "R1 bus idle", {cs_n, rw_n, ldac_n, clr_n, oe}, 5'b11110);
    chk(!busy && !rd_valid, "R1 flags low", {busy, rd_valid}, 0);
    mon = 1;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 4; c++) begin
        logic [15:0] v;
        v = (r == 2) ? ((c[0]) ? 16'hFFFF : 16'h0000) : 16'(16'h1357 * (c + 1) + r * 16'h2111);
        issue(2'b00, 2'(c), v, 0);
      end
      issue(2'b10, 2'd0, 0, 0);
      for (int c = 0; c < 4; c++) issue(2'b01, 2'(c), 0, 0);
      issue(2'b11, 2'd0, 0, 0);
      issue(2'b01, 2'd1, 0, 0);
    end
    issue(2'b00, 2'd3, 16'h4C4C, 0);
    issue(2'b10, 2'd2, 0, 1);
    issue(2'b01, 2'd3, 0, 0);
    chk(mem[3] == 16'h4C4C, "R2 ignored command", mem[3], 16'h4C4C);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule